// File: doc/BRIEF.md
# Tracking Loop Fault Monitor

This block watches the loop error of a digital angle-tracking loop and drives a single active-low built-in-test flag. Each clock cycle is one sample. The block takes the magnitude of the signed loop error, which is given in output LSBs. It smooths that magnitude with a first-order low-pass filter and compares the result against a fault threshold. Separate condition inputs force the flag into fault as soon as they are seen. These are an over-velocity indication, a loss of all input signals, and a loss of the reference (when that check is enabled).

The flag does not latch. A large input step drives the filtered error past the threshold and the flag drops. Once the loop settles and the filtered level falls back to the threshold or below, the flag returns to healthy on its own. A single short spike of moderate size is absorbed by the filter and does not trip the flag. The filter time constant is set by a parameter in sample periods and is rounded up to a power of two, so the filter needs only a shift.

Top module: `trk_fault_mon`

## Requirements
- R1: While `rst` is high at a clock edge, the filter state is cleared and `fault_n` is 0 after that edge. After reset is released, `fault_n` stays 0 until the first edge at which the flag is evaluated with no forcing condition and a filtered level at or below the threshold.
- R2: `fault_n` is active low: 0 means fault and 1 means healthy.
- R3: The magnitude stage takes the absolute value of the two's-complement `loop_err`, for both signs and for the most negative code (-32768 gives 32768).
- R4: The filter keeps an accumulator A, which is cleared by reset. Each cycle it updates as A <= A - (A >> K) + m, where m is the registered magnitude and K = ceil(log2(TAU_SAMPLES)) (K = 4 by default). The filtered level is A >> K. For a constant error it settles to exactly |err|.
- R5: A filtered level strictly above THRESH (default 100) gives `fault_n` = 0 at the next edge. A level at or below THRESH does not. The filtered level is already two register stages behind the error input.
- R6: A single-sample error whose magnitude is below THRESH·2^K does not trip the flag when the filter starts from zero. Example: 1500 does not trip with the defaults, and 1700 does.
- R7: `sig_loss` or `over_vel` high at a clock edge gives `fault_n` = 0 after that same edge, whatever the filtered level.
- R8: With REF_LOSS_EN = 1, `ref_loss` forces a fault in the same way as in R7. With REF_LOSS_EN = 0, `ref_loss` has no effect on `fault_n`.
- R9: Once every forcing input is low and the filtered level is at or below THRESH, `fault_n` returns to 1 at the next edge without any clearing action.
- R10: A large error step followed by a decaying error trips the flag and later clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| loop_err | input | ERR_W (16) | Signed loop error in output LSBs |
| over_vel | input | 1 | Loop cannot keep up with the input |
| sig_loss | input | 1 | All input signals lost |
| ref_loss | input | 1 | Reference lost (used when REF_LOSS_EN = 1) |
| fault_n | output | 1 | Built-in-test flag, 0 = fault |

## Verification
A change on `loop_err` before edge n reaches `fault_n` after edge n+2, because it passes three registers: magnitude, accumulator and flag. A forcing input reaches the flag after edge n. The bench drives inputs on falling edges. It updates an arithmetic model on the same rising edges as the design and compares the flag on every falling edge, so both latencies are checked cycle by cycle. On top of this, the bench holds each error value in a sweep around plus and minus the threshold until the filter settles. It then checks the flag against a direct comparison of |err| with THRESH.

// File: rtl/trk_fault_pkg.sv
package trk_fault_pkg;

    // Encoding of the active-low built-in-test flag
    typedef enum logic {
        FLAG_FAULT = 1'b0,
        FLAG_OK    = 1'b1
    } flag_e;

    // Conditions that force a fault independently of the filtered error
    typedef struct packed {
        logic sig_loss;
        logic ref_loss;
        logic over_vel;
    } cond_t;

    // Shift amount approximating a time constant given in sample periods
    function automatic int unsigned tau_shift(input int unsigned tau);
        return (tau <= 1) ? 0 : $clog2(tau);
    endfunction

endpackage

// File: rtl/trk_err_mag.sv
module trk_err_mag #(
    parameter int unsigned ERR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [ERR_W-1:0] err_i,
    output logic        [ERR_W-1:0] mag_o
);

    logic [ERR_W-1:0] abs_c;

    // Two's-complement negation fits in ERR_W unsigned bits, including the most negative code
    always_comb begin
        if (err_i[ERR_W-1]) abs_c = ~$unsigned(err_i) + 1'b1;
        else                abs_c = $unsigned(err_i);
    end

    always_ff @(posedge clk) begin
        if (rst) mag_o <= '0;
        else     mag_o <= abs_c;
    end

    // R3: a zero error yields a zero magnitude one cycle later
    a_r3_zero_err: assert property (@(posedge clk) disable iff (rst)
        (err_i == '0) |=> (mag_o == '0));

    // R3: a non-zero error never yields a zero magnitude
    a_r3_nonzero_err: assert property (@(posedge clk) disable iff (rst)
        (err_i != '0) |=> (mag_o != '0));

endmodule

// File: rtl/trk_err_lpf.sv
module trk_err_lpf #(
    parameter int unsigned MAG_W = 16,
    parameter int unsigned SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MAG_W-1:0] mag_i,
    output logic [MAG_W-1:0] lvl_o
);

    localparam int unsigned ACC_W = MAG_W + SHIFT;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;

    // Leaky integrator: the accumulator stays within ACC_W bits because its fixed point is mag << SHIFT
    always_comb begin
        acc_d = acc_q - (acc_q >> SHIFT) + ACC_W'(mag_i);
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    assign lvl_o = acc_q[ACC_W-1:SHIFT];

    // R4: the level never falls while the input is at or above it
    a_r4_rise: assert property (@(posedge clk) disable iff (rst)
        (mag_i >= lvl_o) |=> (lvl_o >= $past(lvl_o)));

    // R4: the level never rises while the input is at or below it
    a_r4_fall: assert property (@(posedge clk) disable iff (rst)
        (mag_i <= lvl_o) |=> (lvl_o <= $past(lvl_o)));

endmodule

// File: rtl/trk_fault_flag.sv
module trk_fault_flag
    import trk_fault_pkg::*;
#(
    parameter int unsigned MAG_W       = 16,
    parameter int unsigned THRESH      = 100,
    parameter bit          REF_LOSS_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MAG_W-1:0] lvl_i,
    input  cond_t            cond_i,
    output logic             flt_n_o
);

    localparam logic [MAG_W-1:0] THR_V = MAG_W'(THRESH);

    logic force_c;
    logic over_c;

    generate
        if (REF_LOSS_EN) begin : g_ref
            assign force_c = cond_i.sig_loss | cond_i.over_vel | cond_i.ref_loss;
        end else begin : g_noref
            assign force_c = cond_i.sig_loss | cond_i.over_vel;
        end
    endgenerate

    assign over_c = (lvl_i > THR_V);

    always_ff @(posedge clk) begin
        if (rst)                   flt_n_o <= FLAG_FAULT;
        else if (force_c || over_c) flt_n_o <= FLAG_FAULT;
        else                       flt_n_o <= FLAG_OK;
    end

    // R1: reset leaves the flag in fault
    a_r1_reset_fault: assert property (@(posedge clk)
        rst |=> (flt_n_o == FLAG_FAULT));

    // R7: signal loss or over-velocity forces a fault at the next edge
    a_r7_force: assert property (@(posedge clk) disable iff (rst)
        (cond_i.sig_loss || cond_i.over_vel) |=> (flt_n_o == FLAG_FAULT));

    // R5: a filtered level above threshold gives a fault
    a_r5_over_thr: assert property (@(posedge clk) disable iff (rst)
        (lvl_i > THR_V) |=> (flt_n_o == FLAG_FAULT));

    // R9: quiet conditions and a settled level clear the flag without help
    a_r9_autoclear: assert property (@(posedge clk) disable iff (rst)
        (!cond_i.sig_loss && !cond_i.over_vel && !cond_i.ref_loss && lvl_i <= THR_V)
        |=> (flt_n_o == FLAG_OK));

endmodule

// File: rtl/trk_fault_mon.sv
module trk_fault_mon
    import trk_fault_pkg::*;
#(
    parameter int unsigned ERR_W       = 16,
    parameter int unsigned TAU_SAMPLES = 16,
    parameter int unsigned THRESH      = 100,
    parameter bit          REF_LOSS_EN = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [ERR_W-1:0] loop_err,
    input  logic                    over_vel,
    input  logic                    sig_loss,
    input  logic                    ref_loss,
    output logic                    fault_n
);

    localparam int unsigned SHIFT = tau_shift(TAU_SAMPLES);

    logic [ERR_W-1:0] mag;
    logic [ERR_W-1:0] lvl;
    cond_t            cond;

    assign cond.sig_loss = sig_loss;
    assign cond.ref_loss = ref_loss;
    assign cond.over_vel = over_vel;

    trk_err_mag #(.ERR_W(ERR_W)) u_mag (
        .clk   (clk),
        .rst   (rst),
        .err_i (loop_err),
        .mag_o (mag)
    );

    trk_err_lpf #(.MAG_W(ERR_W), .SHIFT(SHIFT)) u_lpf (
        .clk   (clk),
        .rst   (rst),
        .mag_i (mag),
        .lvl_o (lvl)
    );

    trk_fault_flag #(
        .MAG_W       (ERR_W),
        .THRESH      (THRESH),
        .REF_LOSS_EN (REF_LOSS_EN)
    ) u_flag (
        .clk     (clk),
        .rst     (rst),
        .lvl_i   (lvl),
        .cond_i  (cond),
        .flt_n_o (fault_n)
    );

    // R2: the flag is a clean two-level output once out of reset
    a_r2_flag_known: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(fault_n));

endmodule

// File: tb/trk_fault_mon_bench.sv
module trk_fault_mon_bench;

    localparam int THR = 100;
    localparam int K   = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [15:0] loop_err = '0;
    logic               over_vel = 1'b0;
    logic               sig_loss = 1'b0;
    logic               ref_loss = 1'b0;
    logic               fault_n;
    logic               fault_n_noref;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // Arithmetic model state
    int   m_mag = 0;
    int   m_acc = 0;
    logic m_flag = 1'b0;
    logic m_flag2 = 1'b0;

    always #2 clk = ~clk;

    trk_fault_mon u_trk_fault_mon (
        .clk(clk), .rst(rst), .loop_err(loop_err), .over_vel(over_vel),
        .sig_loss(sig_loss), .ref_loss(ref_loss), .fault_n(fault_n)
    );

    trk_fault_mon #(.REF_LOSS_EN(1'b0)) u_noref (
        .clk(clk), .rst(rst), .loop_err(loop_err), .over_vel(over_vel),
        .sig_loss(sig_loss), .ref_loss(ref_loss), .fault_n(fault_n_noref)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: fault_n=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Model: magnitude, leaky accumulator and flag registers, same edges as the design (R3, R4, R5, R7, R8)
    always @(posedge clk) begin
        if (rst) begin
            m_mag   <= 0;
            m_acc   <= 0;
            m_flag  <= 1'b0;
            m_flag2 <= 1'b0;
        end else begin
            m_mag   <= iabs(int'(loop_err));
            m_acc   <= m_acc - (m_acc >>> K) + m_mag;
            m_flag  <= !(sig_loss || over_vel || ref_loss || ((m_acc >>> K) > THR));
            m_flag2 <= !(sig_loss || over_vel || ((m_acc >>> K) > THR));
        end
    end

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        cycles++;
        chk(cur_req, fault_n, m_flag);
        chk({cur_req, " R8"}, fault_n_noref, m_flag2);
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int saw_fault;
        // R1: reset holds the flag low
        hold(3);
        chk("R1", fault_n, 1'b0);
        rst = 1'b0;
        hold(1);
        chk("R1", fault_n, 1'b1);
        cur_req = "R2";
        hold(20);
        chk("R2", fault_n, 1'b1);

        // R5, R3: sweep around the threshold with both signs
        cur_req = "R5";
        for (int v = 90; v <= 110; v++) begin
            for (int s = 0; s < 2; s++) begin
                loop_err = (s == 0) ? 16'(v) : 16'(-v);
                hold(200);
                chk("R5", fault_n, (v <= THR));
            end
        end

        // R3: extreme codes, including the most negative one
        cur_req = "R3";
        loop_err = 16'sh8000;
        hold(200);
        chk("R3", fault_n, 1'b0);
        loop_err = 16'sh7fff;
        hold(200);
        chk("R3", fault_n, 1'b0);

        // R4, R9: settle back to zero and clear automatically
        cur_req = "R9";
        loop_err = '0;
        hold(300);
        chk("R9", fault_n, 1'b1);

        // R6: single-sample spikes
        cur_req = "R6";
        loop_err = 16'sd1500;
        hold(1);
        loop_err = '0;
        hold(10);
        chk("R6", fault_n, 1'b1);
        hold(200);
        loop_err = 16'sd1700;
        hold(1);
        loop_err = '0;
        hold(2);
        chk("R6", fault_n, 1'b0);
        hold(200);
        chk("R6", fault_n, 1'b1);

        // R7: forcing inputs act after one edge, R9: then release
        cur_req = "R7";
        sig_loss = 1'b1;
        hold(1);
        chk("R7", fault_n, 1'b0);
        sig_loss = 1'b0;
        hold(1);
        chk("R9", fault_n, 1'b1);
        over_vel = 1'b1;
        hold(1);
        chk("R7", fault_n, 1'b0);
        over_vel = 1'b0;
        hold(1);
        chk("R9", fault_n, 1'b1);

        // R8: reference loss with and without the check enabled
        cur_req = "R8";
        ref_loss = 1'b1;
        hold(3);
        chk("R8", fault_n, 1'b0);
        chk("R8", fault_n_noref, 1'b1);
        ref_loss = 1'b0;
        hold(1);
        chk("R8", fault_n, 1'b1);

        // R10: large step, then a decaying error as the loop settles
        cur_req = "R10";
        saw_fault = 0;
        for (int t = 0; t < 48; t++) begin
            loop_err = 16'(3000 >>> (t / 4));
            @(negedge clk);
            if (fault_n == 1'b0) saw_fault = 1;
        end
        loop_err = '0;
        hold(300);
        chk("R10", logic'(saw_fault != 0), 1'b1);
        chk("R10", fault_n, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule